// File: doc/BRIEF.md
# Epoch Downgrade Race Checker

This block keeps, for one hardware thread, a small fully associative table of the cache blocks that thread has touched since its last synchronization point. For each block it holds the coherence rank the thread expects to still own and the instruction address of the thread's latest access to that block. A lower rank means that another agent has taken the block away from this cache. Such a downgrade inside one synchronization-free interval means a conflicting remote access overlapped this thread's interval, and the block reports it as a possible data race.

Two paths produce reports. The first is a check made before each access, which compares the state just read from the cache against the table. The second is a sweep at the end of the interval. The sweep walks the table one slot per step and, for each live slot, asks the cache for the block's present state over a request/acknowledge handshake. This catches downgrades that no later local access revealed. After the sweep the table is emptied and a one-cycle completion pulse is given. An update made after each access raises the stored rank to the larger of the stored and current ranks. It never lowers the rank to whatever state the access left behind.

Top module: `epoch_race_table`

## Requirements
- R1: After reset, race_valid, overflow, sweep_busy, sweep_done and qry_req are all 0 and the table holds no entries.
- R2: A cycle with epoch_begin high, while no sweep is running, empties the table and clears overflow. An access in that same cycle is ignored, and no later check can hit an entry recorded before it.
- R3: State codes are I=0, S=1, E=2, M=3 and NotPresent=4, and codes 5 to 7 are treated as NotPresent. Ranks are M=2, E=S=1, I=0. A pre-access check whose address hits an entry and whose present state has a lower rank than the entry gives race_valid for one cycle, starting in the cycle after the check. race_addr is the checked address and race_pc is the instruction address stored in the entry.
- R4: A pre-access check gives no report when the address misses, when the state is NotPresent, or when the ranks are equal. This includes a change from E to S.
- R5: A post-access event that hits an entry sets the stored rank to the larger of the stored rank and the present state's rank, and replaces the stored instruction address. A NotPresent state leaves the rank unchanged.
- R6: A post-access event that misses, with a state other than NotPresent, takes the lowest free slot. If all 16 slots are in use, the event is dropped and overflow is set until the next epoch_begin. A missing NotPresent event allocates nothing.
- R7: epoch_end starts a sweep over the slots in index order, and slots are filled in order of first access. For each live slot, qry_req is held with a steady qry_addr until qry_ack. A returned state that is a downgrade by the rules of R3 and R4 gives a race report carrying that slot's address and instruction address. An empty slot takes one cycle.
- R8: When the last slot has been handled, the table is emptied, sweep_busy falls and sweep_done is high for exactly one cycle.
- R9: While sweep_busy is high, pre-access, post-access, epoch_begin and epoch_end inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epoch_begin | input | 1 | Start of a synchronization-free interval |
| epoch_end | input | 1 | End of interval; starts the sweep |
| pre_valid | input | 1 | Pre-access check strobe |
| pre_addr | input | AW | Block address being checked |
| pre_state | input | 3 | Present cache state of that block |
| post_valid | input | 1 | Post-access update strobe |
| post_addr | input | AW | Block address just accessed |
| post_pc | input | PW | Instruction address of that access |
| post_state | input | 3 | Cache state read for the access |
| qry_req | output | 1 | Sweep state query request |
| qry_addr | output | AW | Block address being queried |
| qry_ack | input | 1 | Query answered this cycle |
| qry_state | input | 3 | Queried state, valid with qry_ack |
| race_valid | output | 1 | Race report strobe |
| race_addr | output | AW | Block address of the report |
| race_pc | output | PW | Instruction address of the previous local access |
| overflow | output | 1 | A new block was dropped because the table was full |
| sweep_busy | output | 1 | End-of-interval sweep in progress |
| sweep_done | output | 1 | One-cycle pulse when the sweep finishes |

## Verification
The assertions assume that qry_ack is raised only while qry_req is high and that qry_state is meaningful only alongside it. They also assume that epoch_begin and epoch_end are single-cycle pulses. The bench drives acknowledges only in answer to a pending request, with a latency between zero and two cycles. It pulses the epoch inputs for one cycle at a time. It deliberately drives accesses and epoch pulses during a sweep, because R9 defines those as ignored.

// File: rtl/epoch_race_table.sv
module epoch_race_table #(
  parameter int AW    = 32,
  parameter int PW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          epoch_begin,
  input  logic          epoch_end,
  input  logic          pre_valid,
  input  logic [AW-1:0] pre_addr,
  input  logic [2:0]    pre_state,
  input  logic          post_valid,
  input  logic [AW-1:0] post_addr,
  input  logic [PW-1:0] post_pc,
  input  logic [2:0]    post_state,
  output logic          qry_req,
  output logic [AW-1:0] qry_addr,
  input  logic          qry_ack,
  input  logic [2:0]    qry_state,
  output logic          race_valid,
  output logic [AW-1:0] race_addr,
  output logic [PW-1:0] race_pc,
  output logic          overflow,
  output logic          sweep_busy,
  output logic          sweep_done
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  function automatic logic [1:0] rank_of(input logic [2:0] s);
    case (s)
      3'd3:       rank_of = 2'd2;
      3'd1, 3'd2: rank_of = 2'd1;
      default:    rank_of = 2'd0;
    endcase
  endfunction

  logic [DEPTH-1:0] vld;
  logic [AW-1:0]    tag [DEPTH];
  logic [1:0]       rk  [DEPTH];
  logic [PW-1:0]    pcs [DEPTH];
  logic [IW-1:0]    ptr;
  logic             busy;

  logic          pre_hit, post_hit, free_any;
  logic [IW-1:0] pre_idx, post_idx, free_idx;

  always_comb begin
    pre_hit  = 1'b0; pre_idx  = '0;
    post_hit = 1'b0; post_idx = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld[i] && tag[i] == pre_addr) begin
        pre_hit = 1'b1; pre_idx = IW'(i);
      end
      if (vld[i] && tag[i] == post_addr) begin
        post_hit = 1'b1; post_idx = IW'(i);
      end
      if (!vld[i]) begin
        free_any = 1'b1; free_idx = IW'(i);
      end
    end
  end

  wire acc_ok    = !busy && !epoch_begin;
  wire pre_pres  = pre_state < 3'd4;
  wire post_pres = post_state < 3'd4;
  wire qry_pres  = qry_state < 3'd4;
  wire [1:0] post_rk = rank_of(post_state);

  wire pre_down = pre_valid && acc_ok && pre_hit && pre_pres &&
                  (rank_of(pre_state) < rk[pre_idx]);
  wire do_post  = post_valid && acc_ok;
  wire alloc    = do_post && !post_hit && post_pres && free_any;
  wire drop     = do_post && !post_hit && post_pres && !free_any;

  assign qry_req    = busy && vld[ptr];
  assign qry_addr   = tag[ptr];
  assign sweep_busy = busy;

  wire sw_down = qry_req && qry_ack && qry_pres && (rank_of(qry_state) < rk[ptr]);
  wire sw_step = busy && (!vld[ptr] || qry_ack);

  always_ff @(posedge clk) begin
    if (do_post && post_hit) begin
      if (post_pres && post_rk > rk[post_idx]) rk[post_idx] <= post_rk;
      pcs[post_idx] <= post_pc;
    end else if (alloc) begin
      tag[free_idx] <= post_addr;
      rk[free_idx]  <= post_rk;
      pcs[free_idx] <= post_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld        <= '0;
      busy       <= 1'b0;
      ptr        <= '0;
      overflow   <= 1'b0;
      race_valid <= 1'b0;
      race_addr  <= '0;
      race_pc    <= '0;
      sweep_done <= 1'b0;
    end else begin
      race_valid <= 1'b0;
      sweep_done <= 1'b0;
      if (busy) begin
        if (sw_down) begin
          race_valid <= 1'b1;
          race_addr  <= tag[ptr];
          race_pc    <= pcs[ptr];
        end
        if (sw_step) begin
          if (ptr == LAST) begin
            busy       <= 1'b0;
            sweep_done <= 1'b1;
            vld        <= '0;
            ptr        <= '0;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
      end else if (epoch_begin) begin
        vld      <= '0;
        overflow <= 1'b0;
      end else begin
        if (pre_down) begin
          race_valid <= 1'b1;
          race_addr  <= pre_addr;
          race_pc    <= pcs[pre_idx];
        end
        if (alloc) vld[free_idx] <= 1'b1;
        if (drop) overflow <= 1'b1;
        if (epoch_end) begin
          busy <= 1'b1;
          ptr  <= '0;
        end
      end
    end
  end

  // R2: a new interval starts from an empty table with overflow clear
  a_r2_begin_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (epoch_begin && !busy) |=> (vld == '0 && !overflow));

  // R6: overflow only rises when every slot was live
  a_r6_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(&vld));

  // R7: a pending query keeps its request and address until answered
  a_r7_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_req && !qry_ack) |=> (qry_req && $stable(qry_addr)));

  // R8: completion pulse leaves an idle, empty table
  a_r8_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (vld == '0 && !busy && !$past(sweep_done)));

  // R3, R7: every report follows a check or an answered query
  a_r3_report_source: assert property (@(posedge clk) disable iff (!rst_n)
    race_valid |-> $past(pre_valid || (qry_req && qry_ack)));

  // R9: nothing is allocated while the sweep runs
  a_r9_no_alloc_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((vld & ~$past(vld)) == '0));

  // R5: a live entry's rank never drops
  for (genvar g = 0; g < DEPTH; g++) begin : g_mono
    a_r5_rank_keep: assert property (@(posedge clk) disable iff (!rst_n)
      vld[g] |=> (!vld[g] || rk[g] >= $past(rk[g])));
  end

endmodule

// File: tb/epoch_race_table_test.sv
module epoch_race_table_test;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        epoch_begin = 0, epoch_end = 0;
  logic        pre_valid = 0, post_valid = 0;
  logic [31:0] pre_addr = 0, post_addr = 0, post_pc = 0;
  logic [2:0]  pre_state = 0, post_state = 0;
  logic        qry_ack = 0;
  logic [2:0]  qry_state = 0;
  logic        qry_req, race_valid, overflow, sweep_busy, sweep_done;
  logic [31:0] qry_addr, race_addr, race_pc;

  always #2.5 clk = ~clk;

  epoch_race_table uut (
    .clk(clk), .rst_n(rst_n), .epoch_begin(epoch_begin), .epoch_end(epoch_end),
    .pre_valid(pre_valid), .pre_addr(pre_addr), .pre_state(pre_state),
    .post_valid(post_valid), .post_addr(post_addr), .post_pc(post_pc),
    .post_state(post_state), .qry_req(qry_req), .qry_addr(qry_addr),
    .qry_ack(qry_ack), .qry_state(qry_state), .race_valid(race_valid),
    .race_addr(race_addr), .race_pc(race_pc), .overflow(overflow),
    .sweep_busy(sweep_busy), .sweep_done(sweep_done)
  );

  int checks = 0, errors = 0, cyc = 0, lat = 0, waitc = 0;
  string phase = "R1";
  logic [2:0] cst [logic [31:0]];

  function automatic int rnk(input logic [2:0] s);
    if (s == 3) return 2;
    if (s == 1 || s == 2) return 1;
    return 0;
  endfunction

  // behavioural reference
  logic [31:0] m_addr[$];
  logic [31:0] m_pc[$];
  int          m_rank[$];
  bit m_ovf, m_busy, m_done, m_rv;
  int m_idx;
  logic [31:0] m_raddr, m_rpc;

  function automatic int find(input logic [31:0] a);
    foreach (m_addr[i]) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr.delete(); m_pc.delete(); m_rank.delete();
      m_ovf = 0; m_busy = 0; m_done = 0; m_rv = 0; m_idx = 0;
    end else begin
      m_rv = 0; m_done = 0;
      if (m_busy) begin
        bit adv;
        adv = 1;
        if (m_idx < m_addr.size()) begin
          adv = qry_ack;
          if (qry_ack && qry_state < 4 && rnk(qry_state) < m_rank[m_idx]) begin
            m_rv = 1; m_raddr = m_addr[m_idx]; m_rpc = m_pc[m_idx];
          end
        end
        if (adv) begin
          if (m_idx == N - 1) begin
            m_busy = 0; m_done = 1;
            m_addr.delete(); m_pc.delete(); m_rank.delete();
          end else m_idx++;
        end
      end else if (epoch_begin) begin
        m_addr.delete(); m_pc.delete(); m_rank.delete(); m_ovf = 0;
      end else begin
        if (pre_valid) begin
          int k;
          k = find(pre_addr);
          if (k >= 0 && pre_state < 4 && rnk(pre_state) < m_rank[k]) begin
            m_rv = 1; m_raddr = pre_addr; m_rpc = m_pc[k];
          end
        end
        if (post_valid) begin
          int k;
          k = find(post_addr);
          if (k >= 0) begin
            if (post_state < 4 && rnk(post_state) > m_rank[k]) m_rank[k] = rnk(post_state);
            m_pc[k] = post_pc;
          end else if (post_state < 4) begin
            if (m_addr.size() < N) begin
              m_addr.push_back(post_addr); m_pc.push_back(post_pc);
              m_rank.push_back(rnk(post_state));
            end else m_ovf = 1;
          end
        end
        if (epoch_end) begin m_busy = 1; m_idx = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit eq;
      chk(race_valid == m_rv, "race_valid", 32'(race_valid), 32'(m_rv));
      if (m_rv) begin
        chk(race_addr == m_raddr, "race_addr", race_addr, m_raddr);
        chk(race_pc == m_rpc, "race_pc", race_pc, m_rpc);
      end
      chk(overflow == m_ovf, "overflow", 32'(overflow), 32'(m_ovf));
      chk(sweep_busy == m_busy, "sweep_busy", 32'(sweep_busy), 32'(m_busy));
      chk(sweep_done == m_done, "sweep_done", 32'(sweep_done), 32'(m_done));
      eq = m_busy && m_idx < m_addr.size();
      chk(qry_req == eq, "qry_req", 32'(qry_req), 32'(eq));
      if (eq) chk(qry_addr == m_addr[m_idx], "qry_addr", qry_addr, m_addr[m_idx]);
    end
  end

  // query responder
  always @(negedge clk) begin
    if (qry_req && !qry_ack && waitc >= lat) begin
      qry_ack <= 1;
      qry_state <= cst.exists(qry_addr) ? cst[qry_addr] : 3'd4;
    end else begin
      waitc = (qry_req && !qry_ack) ? waitc + 1 : 0;
      qry_ack <= 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL %s watchdog: actual %0d expected 0", phase, cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic clr();
    epoch_begin = 0; epoch_end = 0; pre_valid = 0; post_valid = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask
  task automatic pre(input logic [31:0] a, input logic [2:0] s);
    @(negedge clk); clr(); pre_valid = 1; pre_addr = a; pre_state = s;
  endtask
  task automatic post(input logic [31:0] a, input logic [31:0] pc, input logic [2:0] s);
    @(negedge clk); clr(); post_valid = 1; post_addr = a; post_pc = pc; post_state = s;
  endtask
  task automatic ebegin();
    @(negedge clk); clr(); epoch_begin = 1;
  endtask
  task automatic eend();
    @(negedge clk); clr(); epoch_end = 1;
  endtask
  task automatic wait_done();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); clr();
      if (sweep_done) break;
    end
  endtask

  initial begin
    // R1: reset state
    idle(3); rst_n = 1; idle(3);

    // R2: clearing at interval start
    phase = "R2";
    ebegin(); post(32'h100, 32'h10, 3); ebegin(); pre(32'h100, 0); idle(2);

    // R3: downgrades caught before access
    phase = "R3";
    ebegin();
    post(32'h200, 32'h11, 3); pre(32'h200, 1);
    post(32'h240, 32'h22, 2); pre(32'h240, 0);
    post(32'h280, 32'h33, 1); pre(32'h280, 0);
    pre(32'h200, 6); idle(2);

    // R4: equal rank, miss and evicted give nothing
    phase = "R4";
    post(32'h300, 32'h44, 2); pre(32'h300, 1);
    pre(32'h9990, 0); pre(32'h240, 4); idle(2);

    // R5: ordered maximum update
    phase = "R5";
    post(32'h400, 32'h51, 1); post(32'h400, 32'h52, 3); pre(32'h400, 2);
    post(32'h440, 32'h53, 3); post(32'h440, 32'h54, 0); pre(32'h440, 1);
    post(32'h440, 32'h55, 4); pre(32'h440, 0); idle(2);

    // R6: allocation, NotPresent miss, overflow
    phase = "R6";
    ebegin(); post(32'h500, 32'h60, 4); pre(32'h500, 0);
    for (int i = 0; i < N; i++) post(32'h1000 + 32'(i) * 64, 32'h700 + 32'(i), 3);
    post(32'h5000, 32'h7ff, 3); pre(32'h5000, 0); idle(2);
    phase = "R2"; ebegin(); idle(2);

    // R7 / R9: sweep with latency, inputs during sweep ignored
    phase = "R7";
    lat = 2;
    post(32'h600, 32'h81, 3); cst[32'h600] = 1;
    post(32'h640, 32'h82, 2); cst[32'h640] = 1;
    post(32'h680, 32'h83, 1); cst[32'h680] = 0;
    post(32'h6c0, 32'h84, 3); cst[32'h6c0] = 4;
    post(32'h700, 32'h85, 3); cst[32'h700] = 0;
    eend();
    phase = "R9";
    post(32'h780, 32'h90, 3); pre(32'h600, 0); ebegin(); eend();
    phase = "R8";
    wait_done(); idle(1);
    pre(32'h600, 0); idle(2);

    // R8: empty-table sweep
    eend(); wait_done(); idle(2);

    // R7: full table sweep, zero latency
    phase = "R7";
    lat = 0;
    ebegin();
    for (int i = 0; i < N; i++) begin
      post(32'h2000 + 32'(i) * 64, 32'ha00 + 32'(i), (i % 2 == 0) ? 3'd3 : 3'd2);
      cst[32'h2000 + 32'(i) * 64] = 3'(i % 4);
    end
    eend(); wait_done(); idle(3);

    // R9: epoch_end in same cycle as access still records the access
    phase = "R9";
    lat = 1;
    ebegin();
    @(negedge clk); clr(); post_valid = 1; post_addr = 32'h3000; post_pc = 32'hbb; post_state = 3;
    epoch_end = 1; cst[32'h3000] = 0;
    wait_done(); idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule